// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer ratio N = 8·M + A. It models a dual-modulus prescaler in logic, running at the input clock. The prescaler divides by 9 or by 8. A small swallow counter picks the prescaler modulus and a wider main counter counts prescaler cycles. Because A steps the ratio one input period at a time, every legal ratio is reachable, with a step of one input period. The ratio word is applied by a holding register upstream and may change at any time.

The divided output is a one-cycle pulse. It serves as the feedback edge for a phase/frequency comparator. A half-rate square wave is also kept. When test mode is on, that square wave is driven onto a test port.

Top module: `pswallow_div`

## Requirements
- R1: The ratio word splits into two fields. M is bits [14:3] and A is bits [2:0].
- R2: For any word with M ≥ 7, consecutive rising pulses on `fpd` are exactly 8·M + A input clocks apart.
- R3: `fpd` is high for exactly one input clock per division cycle. This holds for the smallest legal ratio, M = 7 and A = 0, which gives 56.
- R4: A word change is sampled only in the clock that ends a division cycle. A change in the middle of a period leaves that period's length unchanged. The next period uses the new word.
- R5: Within one period, the prescaler divides by 9 for the first A prescaler cycles and by 8 for the remaining M − A. This gives the exact step across A = 0 to A = 7.
- R6: While `test_en` is 0, `p0_out` is held at 0.
- R7: While `test_en` is 1, `p0_out` shows Fpd/2. This is a level that toggles in the same clock in which `fpd` is high, so its period is 2·N.
- R8: While `rst_n` is low, `fpd` and `p0_out` are 0. The first pulse after reset release is seen N + 1 clocks after the first active edge, where one clock is spent loading the word.
- R9: The ratio extremes work. M = 4095 with A = 7 gives 32767, and M = 7 with A = 7 gives 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_word | input | 15 | Division word: M in [14:3], A in [2:0] |
| test_en | input | 1 | Routes Fpd/2 to the test port |
| fpd | output | 1 | One-clock pulse at the end of each division cycle |
| p0_out | output | 1 | Fpd/2 square wave when test mode is on, else 0 |

## Verification
The bench builds the block with its default field widths, a 12-bit main count and a 3-bit swallow count. This puts the full 15-bit ratio range within reach, including the 32767 ceiling and the 56 floor. Random words keep M small enough that many periods fit in a run. Every swallow value from 0 to 7 is reached, along with word changes placed at arbitrary points inside a period.

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int M_W = 12,
  parameter int A_W = 3
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic [M_W+A_W-1:0]   ratio_word,
  input  logic                 test_en,
  output logic                 fpd,
  output logic                 p0_out
);
  localparam int W    = M_W + A_W;
  localparam int BASE = 1 << A_W;
  localparam int PC_W = A_W + 1;

  logic [PC_W-1:0] pre_cnt;
  logic [M_W-1:0]  m_rem;
  logic [A_W-1:0]  a_rem;
  logic            half;

  wire [M_W-1:0]  m_new    = ratio_word[W-1:A_W];
  wire [A_W-1:0]  a_new    = ratio_word[A_W-1:0];
  wire            swallow  = (a_rem != '0);
  wire [PC_W-1:0] pre_last = swallow ? PC_W'(BASE) : PC_W'(BASE - 1);
  wire            pre_end  = (pre_cnt == pre_last);
  wire            idle     = (m_rem == '0);
  wire            wrap     = pre_end && (m_rem == M_W'(1));

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      m_rem   <= '0;
      a_rem   <= '0;
      fpd     <= 1'b0;
      half    <= 1'b0;
    end else begin
      fpd <= wrap;
      if (wrap) half <= ~half;
      if (idle || wrap) begin
        pre_cnt <= '0;
        m_rem   <= m_new;
        a_rem   <= a_new;
      end else if (pre_end) begin
        pre_cnt <= '0;
        m_rem   <= m_rem - M_W'(1);
        if (swallow) a_rem <= a_rem - A_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PC_W'(1);
      end
    end
  end

  assign p0_out = test_en & half;
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int M_W = 12,
  parameter int A_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [M_W+A_W-1:0] ratio_word,
  input logic               test_en,
  input logic               fpd,
  input logic               p0_out,
  input logic               half,
  input logic [M_W-1:0]     m_rem,
  input logic [A_W-1:0]     a_rem
);
  localparam int W = M_W + A_W;

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpd |=> !fpd);

  // R7
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpd |-> (half != $past(half)));

  // R6
  p0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> !p0_out);

  // R1
  field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpd |-> (m_rem == $past(ratio_word[W-1:A_W]) && a_rem == $past(ratio_word[A_W-1:0])));

  // R5
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rem != '0) |-> (M_W'(a_rem) <= m_rem));
endmodule

bind pswallow_div pswallow_div_chk #(.M_W(M_W), .A_W(A_W)) u_chk (
  .clk(clk_in), .rst_n(rst_n), .ratio_word(ratio_word), .test_en(test_en),
  .fpd(fpd), .p0_out(p0_out), .half(half), .m_rem(m_rem), .a_rem(a_rem)
);

// File: tb/sim_pswallow_div.sv
`timescale 1ns/1ps
module sim_pswallow_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] word = {12'd9, 3'd5};
  logic test_en = 1'b1;
  logic fpd, p0_out;

  always #2.5 clk = ~clk;

  pswallow_div u0 (.clk_in(clk), .rst_n(rst_n), .ratio_word(word),
                   .test_en(test_en), .fpd(fpd), .p0_out(p0_out));

  int compared = 0, mismatched = 0, cycles = 0;
  int cnt = 0, exp_n = 0;
  bit half_m = 0, hung = 0;
  string tag = "R8";

  function automatic int ratio_of(logic [14:0] w);
    return 8 * int'(w[14:3]) + int'(w[2:0]);
  endfunction

  task automatic check(string t, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cycles);
    end
  endtask

  task automatic step();
    bit ef;
    @(negedge clk);
    cycles++;
    if (cycles > 190000) begin
      if (!hung) begin
        hung = 1;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
      return;
    end
    cnt++;
    ef = (cnt == exp_n);
    if (ef) half_m = ~half_m;
    check(tag, "fpd", int'(fpd), int'(ef));
    check(test_en ? "R7" : "R6", "p0_out", int'(p0_out), int'(test_en & half_m));
    if (ef) begin
      cnt = 0;
      exp_n = ratio_of(word);
    end
  endtask

  task automatic pulses(int n);
    int got = 0;
    while (got < n && !hung) begin
      step();
      if (fpd) got++;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R8", "fpd in reset", int'(fpd), 0);
      check("R8", "p0 in reset", int'(p0_out), 0);
    end
    rst_n = 1'b1;
    cnt = 0;
    exp_n = ratio_of(word) + 1;
    tag = "R8";
    pulses(1);
    tag = "R1";
    pulses(2);
    word = {12'd5 + 12'd0, 3'd0} | {12'd13, 3'd1};
    pulses(3);
    tag = "R3";
    word = {12'd7, 3'd0};
    pulses(3);
    tag = "R5";
    for (int a = 0; a < 8; a++) begin
      word = {12'd7, a[2:0]};
      pulses(2);
      word = {12'd11, a[2:0]};
      pulses(2);
    end
    tag = "R6";
    test_en = 1'b0;
    pulses(3);
    tag = "R7";
    test_en = 1'b1;
    pulses(3);
    tag = "R4";
    for (int k = 0; k < 6; k++) begin
      word = {12'd20 + 12'(k), 3'(k)};
      pulses(1);
      repeat (7 + 13 * k) step();
      word = {12'd9 + 12'(k), 3'(7 - k)};
      pulses(2);
    end
    tag = "R2";
    for (int k = 0; k < 16; k++) begin
      int m = 7 + int'($urandom_range(0, 293));
      word = {12'(m), 3'($urandom_range(0, 7))};
      pulses(2);
      test_en = $urandom_range(0, 1) != 0;
    end
    test_en = 1'b1;
    tag = "R9";
    word = {12'd7, 3'd7};
    pulses(3);
    word = {12'd4095, 3'd7};
    pulses(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule